// File: doc/BRIEF.md
# Addressed Peripheral Read Responder

This block sits between one peripheral register and a shared, tri-stated data bus driven by a host processor. Each peripheral on the bus owns one register and is identified by a 4-bit identity address strapped in hardware. The host starts a read by placing a target address on the address lines and raising its read strobe. Every responder on the bus compares that address with its own strap, and only the matching one answers.

While waiting, the responder leaves the bus at high impedance and copies the peripheral register into a private holding register on every clock. At the first clock edge where the address matches the strap and the strobe is high, it moves to its sending state. It then drives the held copy onto the bus and keeps it frozen until the host lowers the strobe. At the first edge where the strobe is seen low, it releases the bus and goes back to waiting. The block has only plain control pins and a shared bus. It has no valid/ready stream: the read strobe is the whole handshake, and the host holds the bus transfer open for as long as it needs.

Top module: `periph_read_responder`

## Requirements
- R1: While reset (rst_n low) is applied and after it is released with no read, the block does not drive the data bus; with a pull-up on the bus it reads 0xFFFFFFFF.
- R2: In the waiting state the bus stays at high impedance whatever value the peripheral register takes.
- R3: When bus_rd is 1 and bus_addr equals slot_id at a rising clock edge, the bus from just after that edge carries the peripheral value sampled at that same edge.
- R4: A read strobe at an address that differs from slot_id leaves the bus undriven.
- R5: An address equal to slot_id with bus_rd at 0 leaves the bus undriven.
- R6: While sending, the driven value does not change when the peripheral register or the address lines change.
- R7: The bus stays driven while bus_rd is held high and until the first rising edge at which bus_rd is sampled 0; it is released to high impedance right after that edge.
- R8: After a release the holding register tracks the peripheral again, so the next matching read returns the peripheral value at its own start edge.
- R9: Every strap value from 0 to 15 selects the block, including the extremes 0x0 and 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Target address from the host |
| bus_rd | input | 1 | Host read strobe, active high |
| bus_data | inout | 32 | Shared tri-stated data bus |
| slot_id | input | 4 | Hardware-strapped identity address |
| periph_val | input | 32 | Current value of the peripheral register |

## Verification
The assertions assume that slot_id is static for the time a read lasts, and that the host does not start a new read before the old one has been released. The bench changes the strap only while the block is waiting, and it always lowers bus_rd for at least one full clock between reads. The bus is observed through a pull-up. For this reason an undriven bus reads as all ones, and no expected driven value in the stimulus is all ones. Inputs change on the falling edge, so every rising edge sees stable address, strobe and register values.

// File: rtl/prr_pkg.sv
package prr_pkg;
  typedef enum logic {
    PRR_WAIT = 1'b0,
    PRR_SEND = 1'b1
  } prr_state_t;
endpackage

// File: rtl/prr_match.sv
module prr_match #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              req_rd,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;

  // Bitwise compare, then reduce; a hit needs the strobe too.
  always_comb begin
    diff = req_addr ^ own_addr;
    hit  = req_rd && (diff == '0);
  end
endmodule

// File: rtl/prr_hold.sv
module prr_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] q
);
  // Follows the source while tracking, frozen otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (track) begin
      q <= src;
    end
  end
endmodule

// File: rtl/prr_ctrl.sv
module prr_ctrl
  import prr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       rd,
  output prr_state_t state,
  output logic       track,
  output logic       drive
);
  prr_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PRR_WAIT: if (hit) nxt = PRR_SEND;
      PRR_SEND: if (!rd) nxt = PRR_WAIT;
      default:  nxt = PRR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PRR_WAIT;
    end else begin
      state <= nxt;
    end
  end

  assign track = (state == PRR_WAIT);
  assign drive = (state == PRR_SEND);
endmodule

// File: rtl/periph_read_responder.sv
module periph_read_responder
  import prr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  inout  wire  [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [DATA_W-1:0] periph_val
);
  localparam logic [DATA_W-1:0] FLOAT = {DATA_W{1'bz}};

  logic              hit;
  logic              track;
  logic              drive;
  logic [DATA_W-1:0] held;
  prr_state_t        state;

  prr_match #(.ADDR_W(ADDR_W)) u_match (
    .req_addr (bus_addr),
    .own_addr (slot_id),
    .req_rd   (bus_rd),
    .hit      (hit)
  );

  prr_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .rd    (bus_rd),
    .state (state),
    .track (track),
    .drive (drive)
  );

  prr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .track (track),
    .src   (periph_val),
    .q     (held)
  );

  assign bus_data = drive ? held : FLOAT;

  // R1: a reset cycle always leaves the block waiting
  assert_reset_wait_R1: assert property (@(posedge clk)
    !rst_n |=> (state == PRR_WAIT));

  // R4 / R5: no leaving the waiting state without a strobed address match
  assert_no_stray_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PRR_WAIT) && !(bus_rd && (bus_addr == slot_id))) |=> (state == PRR_WAIT));

  // R3: a strobed match starts sending with the value sampled at that edge
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PRR_WAIT) && bus_rd && (bus_addr == slot_id)) |=> (drive && (held == $past(periph_val))));

  // R6: driven copy frozen while sending continues
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PRR_SEND) && bus_rd) |=> ((state == PRR_SEND) && $stable(held)));

  // R7: strobe low while sending releases the bus at the next edge
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PRR_SEND) && !bus_rd) |=> !drive);
endmodule

// File: tb/sim_periph_read_responder.sv
module sim_periph_read_responder;
  localparam int PERIOD = 10;
  localparam logic [31:0] IDLE_BUS = 32'hFFFF_FFFF;
  localparam int NV = 8;
  // {slot_id, bus_addr, bus_rd, periph_val, expected bus}
  localparam logic [72:0] VEC [NV] = '{
    {4'h3, 4'h3, 1'b1, 32'h1234_5678, 32'h1234_5678},
    {4'h3, 4'h4, 1'b1, 32'h0BAD_F00D, IDLE_BUS},
    {4'h3, 4'h3, 1'b0, 32'h2222_2222, IDLE_BUS},
    {4'h0, 4'h0, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {4'hF, 4'hF, 1'b1, 32'h8000_0001, 32'h8000_0001},
    {4'hF, 4'h7, 1'b1, 32'h0000_0001, IDLE_BUS},
    {4'h9, 4'h9, 1'b1, 32'hCAFE_0000, 32'hCAFE_0000},
    {4'hA, 4'h5, 1'b0, 32'h0000_0007, IDLE_BUS}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic [3:0]  slot_id = '0;
  logic [31:0] periph_val = '0;
  tri   [31:0] bus;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  for (genvar i = 0; i < 32; i++) begin : g_pu
    pullup (bus[i]);
  end

  always #(PERIOD/2) clk = ~clk;

  periph_read_responder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_data   (bus),
    .slot_id    (slot_id),
    .periph_val (periph_val)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bus=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: bus=%h expected=finish", bus);
    finish_run();
  end

  initial begin
    // R1: bus undriven during and after reset
    repeat (2) @(negedge clk);
    periph_val = 32'h5555_AAAA;
    check("R1 in reset", bus, IDLE_BUS);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", bus, IDLE_BUS);
    // R2: waiting, register changing, bus stays released
    periph_val = 32'h0F0F_0F0F;
    @(negedge clk);
    check("R2 waiting", bus, IDLE_BUS);

    // vector table: R3 R4 R5 R9
    for (int k = 0; k < NV; k++) begin
      slot_id    = VEC[k][72:69];
      bus_addr   = VEC[k][68:65];
      bus_rd     = VEC[k][64];
      periph_val = VEC[k][63:32];
      @(negedge clk);
      check($sformatf("R3/R4/R5/R9 vector %0d", k), bus, VEC[k][31:0]);
      bus_rd = 1'b0;
      @(negedge clk);
      check($sformatf("R7 vector %0d release", k), bus, IDLE_BUS);
    end

    // R6: frozen while sending
    slot_id = 4'h6; bus_addr = 4'h6; bus_rd = 1'b1; periph_val = 32'h1111_0001;
    @(negedge clk);
    check("R3 start", bus, 32'h1111_0001);
    periph_val = 32'h2222_0002; bus_addr = 4'h1;
    @(negedge clk);
    check("R6 register change ignored", bus, 32'h1111_0001);
    periph_val = 32'h3333_0003;
    repeat (3) @(negedge clk);
    check("R6 held across cycles", bus, 32'h1111_0001);
    // R7: still driven until the edge that samples strobe low
    bus_rd = 1'b0;
    #1;
    check("R7 before edge", bus, 32'h1111_0001);
    @(negedge clk);
    check("R7 released", bus, IDLE_BUS);

    // R8: tracks again, new read gets new value
    periph_val = 32'h4444_0004;
    @(negedge clk);
    check("R2 waiting after release", bus, IDLE_BUS);
    bus_addr = 4'h6; bus_rd = 1'b1; periph_val = 32'h5A5A_0005;
    @(negedge clk);
    check("R8 fresh value", bus, 32'h5A5A_0005);
    bus_rd = 1'b0;
    @(negedge clk);

    // R1: reset in the middle of a read releases the bus
    bus_rd = 1'b1; periph_val = 32'h6060_0006;
    @(negedge clk);
    check("R3 before reset", bus, 32'h6060_0006);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-read", bus, IDLE_BUS);
    bus_rd = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", bus, IDLE_BUS);

    finish_run();
  end
endmodule